// File: doc/BRIEF.md
# SMBus Host Command and Status Controller

This block is the software-facing front end of an SMBus host. Firmware loads a target address, a command byte and two data bytes through a byte-wide register port. It then writes the control register with a protocol code and the start bit. A transaction engine steps through the byte slots of the chosen protocol and sends each outgoing byte out on a transmit strobe. Bytes read from the target are stored in the data registers. The line drivers are modelled by a bit-timing engine in which every byte slot, acknowledge bit included, lasts nine bit times. Two injection inputs make a transmitted byte end in a missing acknowledge or a lost arbitration.

The outcome is reported through a status register whose event flags are cleared by writing ones. A kill bit in the control register aborts a running transaction and leaves the failed flag set. An alert input raises its own sticky flag.

Top module: `smbh_host`

## Requirements
- R1: After reset every register reads 0, the transmit strobe is low, and no byte is sent until a start is written.
- R2: Register offsets: status 0, control 2, command 3, address 4, data-low 5, data-high 6; any other offset reads 0. Control reads back with the PEC-enable bit 7 and the protocol field [4:2], and the start bit 6 and kill bit 1 read 0. Status bits 7 and 6 read 0.
- R3: A control write with bit 6 (0x40) set and bit 1 clear, made while idle, sets host busy (status bit 0) in the next cycle.
- R4: The protocol field [4:2] selects the byte slots, each lasting 9*BIT_CYCLES cycles, and busy stays high for exactly the slot count times that length. Code 0 (quick) sends the address register as written. Code 1 (byte) sends the address, then either the command byte (write, address bit 0 = 0) or one received byte (read). Code 2 (byte-data) sends the address with bit 0 cleared and the command, then either data-low (write) or the address with bit 0 set followed by one received byte (read). Code 3 (word) is the same as code 2 but moves two data bytes.
- R5: The address register holds the 7-bit target address in bits [7:1] and the direction in bit 0 (1 = read). A byte-protocol write sends the command register value.
- R6: A word read stores dev_word[7:0] in data-low and dev_word[15:8] in data-high. Byte and byte-data reads store dev_word[7:0] in data-low only and leave data-high unchanged.
- R7: When busy clears, exactly one of these flags is set: complete (bit 1, 0x02), device error (bit 2, 0x04), bus error (bit 3, 0x08) or failed (bit 4, 0x10).
- R8: If arb_inj is high when a transmitted byte ends, the transaction stops with a bus error. Otherwise, if nack_inj is high, it stops with a device error. Either way no further byte is sent and the data registers are not changed.
- R9: Protocol codes 4 to 7 are not supported. They end after one busy cycle with the failed flag set and nothing sent.
- R10: A control write with bit 1 (0x02) set while busy clears busy in the next cycle, sets failed, and sends no further byte. While idle the kill bit has no effect on status and suppresses a start written in the same byte.
- R11: Writing a 1 to status bits 5..1 clears those flags. Writing 0 leaves a flag unchanged. The busy bit cannot be cleared by a write.
- R12: While busy, writes to control (other than kill), command, address, data-low and data-high are ignored, and the running transaction continues undisturbed.
- R13: A rising edge on alert_in sets status bit 5 (0x20). A level held high does not set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | AW | Register offset |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dev_word | input | 16 | Bytes returned by the modelled target on read slots |
| nack_inj | input | 1 | Make transmitted bytes end without acknowledge |
| arb_inj | input | 1 | Make transmitted bytes end in lost arbitration |
| alert_in | input | 1 | Alert line from targets |
| tx_valid | output | 1 | One-cycle strobe: a byte has been transmitted |
| tx_byte | output | 8 | Value of the transmitted byte |

## Verification
A wrong slot index or plan decode shows up within one slot time, as a wrong byte on the transmit strobe or a wrong number of strobes. A miscounting bit engine changes the busy duration. The bench measures that duration to the cycle for every transaction. A flag or busy register holding the wrong state appears in the status read made right after completion or kill, in the same cycle the engine stops. Errors in data capture appear in the data registers when they are read back after each read transaction.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
   typedef enum logic [2:0] {
      SL_ADDR_AS_IS,
      SL_ADDR_WR,
      SL_ADDR_RD,
      SL_CMD,
      SL_D0,
      SL_D1,
      SL_RX0,
      SL_RX1
   } slot_kind_e;

   typedef struct packed {
      slot_kind_e kind;
      logic       last;
   } slot_t;

   localparam int OFS_STAT = 0;
   localparam int OFS_CTRL = 2;
   localparam int OFS_CMD  = 3;
   localparam int OFS_ADDR = 4;
   localparam int OFS_D0   = 5;
   localparam int OFS_D1   = 6;

   localparam int CT_PEC   = 7;
   localparam int CT_START = 6;
   localparam int CT_KILL  = 1;

   localparam logic [2:0] PR_QUICK = 3'd0;
   localparam logic [2:0] PR_BYTE  = 3'd1;
   localparam logic [2:0] PR_BDATA = 3'd2;
   localparam logic [2:0] PR_WORD  = 3'd3;
endpackage

// File: rtl/smbh_plan.sv
module smbh_plan
   import smbh_pkg::*;
(
   input  logic [2:0] proto,
   input  logic       rw,
   input  logic [2:0] idx,
   output slot_t      slot,
   output logic       legal
);
   logic [2:0] count;

   always_comb begin
      legal     = 1'b1;
      count     = 3'd1;
      slot.kind = SL_ADDR_AS_IS;
      case (proto)
         PR_QUICK: count = 3'd1;
         PR_BYTE: begin
            count = 3'd2;
            if (idx == 3'd1) slot.kind = rw ? SL_RX0 : SL_CMD;
         end
         PR_BDATA: begin
            count = rw ? 3'd4 : 3'd3;
            case (idx)
               3'd0:    slot.kind = SL_ADDR_WR;
               3'd1:    slot.kind = SL_CMD;
               3'd2:    slot.kind = rw ? SL_ADDR_RD : SL_D0;
               default: slot.kind = SL_RX0;
            endcase
         end
         PR_WORD: begin
            count = rw ? 3'd5 : 3'd4;
            case (idx)
               3'd0:    slot.kind = SL_ADDR_WR;
               3'd1:    slot.kind = SL_CMD;
               3'd2:    slot.kind = rw ? SL_ADDR_RD : SL_D0;
               3'd3:    slot.kind = rw ? SL_RX0 : SL_D1;
               default: slot.kind = SL_RX1;
            endcase
         end
         default: begin
            legal = 1'b0;
            count = 3'd1;
         end
      endcase
      slot.last = (idx == count - 3'd1);
   end
endmodule

// File: rtl/smbh_bitclk.sv
module smbh_bitclk #(
   parameter int BIT_CYCLES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic slot_done
);
   localparam int BITS_PER_SLOT = 9;

   logic [3:0] bitn;
   logic       ph_wrap;

   if (BIT_CYCLES < 1) begin : g_bad_cycles
      $error("BIT_CYCLES must be at least 1");
   end

   if (BIT_CYCLES == 1) begin : g_nophase
      assign ph_wrap = 1'b1;
   end else begin : g_phase
      localparam int PW = $clog2(BIT_CYCLES);
      logic [PW-1:0] ph;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              ph <= '0;
         else if (!run || ph == PW'(BIT_CYCLES-1)) ph <= '0;
         else                                     ph <= ph + 1'b1;
      end
      assign ph_wrap = (ph == PW'(BIT_CYCLES-1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bitn <= '0;
      else if (!run)    bitn <= '0;
      else if (ph_wrap) bitn <= (bitn == 4'(BITS_PER_SLOT-1)) ? 4'd0 : bitn + 4'd1;
   end

   assign slot_done = run && ph_wrap && (bitn == 4'(BITS_PER_SLOT-1));
endmodule

// File: rtl/smbh_flags.sv
module smbh_flags #(
   parameter int W = 5
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q[i] <= 1'b0;
         else if (set_i[i]) q[i] <= 1'b1;
         else if (clr_i[i]) q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/smbh_host.sv
module smbh_host
   import smbh_pkg::*;
#(
   parameter int BIT_CYCLES = 2,
   parameter int AW = 4
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] reg_addr,
   input  logic          reg_we,
   input  logic [7:0]    reg_wdata,
   output logic [7:0]    reg_rdata,
   input  logic [15:0]   dev_word,
   input  logic          nack_inj,
   input  logic          arb_inj,
   input  logic          alert_in,
   output logic          tx_valid,
   output logic [7:0]    tx_byte
);
   localparam int NFLAG = 5;

   if (AW < 3) begin : g_bad_aw
      $error("AW must cover offset 6");
   end

   logic [2:0]       proto_q;
   logic             pec_q;
   logic [7:0]       cmd_q, addr_q, d0_q, d1_q;
   logic             busy_q;
   logic [2:0]       idx_q;
   logic             alert_d;
   logic [NFLAG-1:0] flags_q;
   logic [3:0]       fin_evt;
   slot_t            slot;
   logic             legal, slot_done, is_tx, rx_ok;
   logic             wr_stat, wr_ctrl, wr_cfg, kill_req, start_req;
   logic [7:0]       tx_sel;

   assign wr_stat   = reg_we && (reg_addr == AW'(OFS_STAT));
   assign wr_ctrl   = reg_we && (reg_addr == AW'(OFS_CTRL));
   assign wr_cfg    = reg_we && !busy_q;
   assign kill_req  = wr_ctrl && reg_wdata[CT_KILL] && busy_q;
   assign start_req = wr_ctrl && reg_wdata[CT_START] && !reg_wdata[CT_KILL] && !busy_q;

   smbh_plan u_plan (
      .proto (proto_q),
      .rw    (addr_q[0]),
      .idx   (idx_q),
      .slot  (slot),
      .legal (legal)
   );

   smbh_bitclk #(.BIT_CYCLES(BIT_CYCLES)) u_bits (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy_q),
      .slot_done (slot_done)
   );

   assign is_tx = (slot.kind != SL_RX0) && (slot.kind != SL_RX1);
   assign rx_ok = busy_q && legal && slot_done && !kill_req;

   always_comb begin
      case (slot.kind)
         SL_ADDR_AS_IS: tx_sel = addr_q;
         SL_ADDR_WR:    tx_sel = {addr_q[7:1], 1'b0};
         SL_ADDR_RD:    tx_sel = {addr_q[7:1], 1'b1};
         SL_CMD:        tx_sel = cmd_q;
         SL_D0:         tx_sel = d0_q;
         SL_D1:         tx_sel = d1_q;
         default:       tx_sel = 8'h00;
      endcase
   end

   // outcome one-hot: {failed, bus error, device error, complete}
   always_comb begin
      fin_evt = '0;
      if (busy_q) begin
         if (kill_req || !legal)                   fin_evt[3] = 1'b1;
         else if (slot_done && is_tx && arb_inj)   fin_evt[2] = 1'b1;
         else if (slot_done && is_tx && nack_inj)  fin_evt[1] = 1'b1;
         else if (slot_done && slot.last)          fin_evt[0] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         idx_q    <= '0;
         alert_d  <= 1'b0;
         tx_valid <= 1'b0;
         tx_byte  <= '0;
         proto_q  <= '0;
         pec_q    <= 1'b0;
         cmd_q    <= '0;
         addr_q   <= '0;
         d0_q     <= '0;
         d1_q     <= '0;
      end else begin
         alert_d <= alert_in;
         if (start_req)     busy_q <= 1'b1;
         else if (|fin_evt) busy_q <= 1'b0;
         if (start_req)                                     idx_q <= '0;
         else if (busy_q && slot_done && fin_evt == 4'd0)   idx_q <= idx_q + 3'd1;
         tx_valid <= rx_ok && is_tx;
         if (rx_ok && is_tx) tx_byte <= tx_sel;
         if (wr_cfg && wr_ctrl) begin
            proto_q <= reg_wdata[4:2];
            pec_q   <= reg_wdata[CT_PEC];
         end
         if (wr_cfg && reg_addr == AW'(OFS_CMD))  cmd_q  <= reg_wdata;
         if (wr_cfg && reg_addr == AW'(OFS_ADDR)) addr_q <= reg_wdata;
         if (wr_cfg && reg_addr == AW'(OFS_D0))   d0_q   <= reg_wdata;
         else if (rx_ok && slot.kind == SL_RX0)   d0_q   <= dev_word[7:0];
         if (wr_cfg && reg_addr == AW'(OFS_D1))   d1_q   <= reg_wdata;
         else if (rx_ok && slot.kind == SL_RX1)   d1_q   <= dev_word[15:8];
      end
   end

   smbh_flags #(.W(NFLAG)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i ({alert_in && !alert_d, fin_evt}),
      .clr_i (wr_stat ? reg_wdata[5:1] : {NFLAG{1'b0}}),
      .q     (flags_q)
   );

   always_comb begin
      reg_rdata = 8'h00;
      case (reg_addr)
         AW'(OFS_STAT): reg_rdata = {2'b00, flags_q, busy_q};
         AW'(OFS_CTRL): reg_rdata = {pec_q, 2'b00, proto_q, 2'b00};
         AW'(OFS_CMD):  reg_rdata = cmd_q;
         AW'(OFS_ADDR): reg_rdata = addr_q;
         AW'(OFS_D0):   reg_rdata = d0_q;
         AW'(OFS_D1):   reg_rdata = d1_q;
         default:       reg_rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/smbh_host_chk.sv
module smbh_host_chk #(
   parameter int AW = 4
)(
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] reg_addr,
   input logic          reg_we,
   input logic [7:0]    reg_wdata,
   input logic          busy_q,
   input logic [3:0]    fin_evt,
   input logic [4:0]    flags_q,
   input logic          tx_valid
);
   logic ctrl_wr;
   assign ctrl_wr = reg_we && (reg_addr == AW'(2));

   assert_busy_from_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(ctrl_wr && reg_wdata[6] && !reg_wdata[1]));

   assert_single_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past($onehot(fin_evt)));

   assert_kill_fails_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && ctrl_wr && reg_wdata[1]) |=> (!busy_q && flags_q[3]));

   assert_busy_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && fin_evt == 4'd0 && ctrl_wr && !reg_wdata[1]) |=> busy_q);

   assert_tx_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(busy_q));
endmodule

bind smbh_host smbh_host_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_we    (reg_we),
   .reg_wdata (reg_wdata),
   .busy_q    (busy_q),
   .fin_evt   (fin_evt),
   .flags_q   (flags_q),
   .tx_valid  (tx_valid)
);

// File: tb/sim_smbh_host.sv
module sim_smbh_host;
   localparam int CLK_PERIOD = 10;
   localparam int BITC = 2;
   localparam int SLOT = 9 * BITC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [15:0] dev_word = '0;
   logic        nack_inj = 1'b0, arb_inj = 1'b0, alert_in = 1'b0;
   logic        tx_valid;
   logic [7:0]  tx_byte;

   int n_chk = 0, n_bad = 0;
   bit summary_done = 0;
   logic [7:0] txq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   smbh_host #(.BIT_CYCLES(BITC), .AW(4)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_word(dev_word),
      .nack_inj(nack_inj), .arb_inj(arb_inj), .alert_in(alert_in),
      .tx_valid(tx_valid), .tx_byte(tx_byte)
   );

   always @(negedge clk) if (rst_n && tx_valid) txq.push_back(tx_byte);

   task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!summary_done) begin
         summary_done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   function automatic int nslots(input logic [2:0] p, input logic rw);
      case (p)
         3'd0: return 1;
         3'd1: return 2;
         3'd2: return rw ? 4 : 3;
         3'd3: return rw ? 5 : 4;
         default: return 0;
      endcase
   endfunction

   function automatic int ntx(input logic [2:0] p, input logic rw);
      case (p)
         3'd0: return 1;
         3'd1: return rw ? 1 : 2;
         3'd2: return 3;
         3'd3: return rw ? 3 : 4;
         default: return 0;
      endcase
   endfunction

   function automatic logic [7:0] expb(input logic [2:0] p, input logic [7:0] a, c, d0, d1, input int i);
      logic [7:0] aw, ar;
      aw = {a[7:1], 1'b0};
      ar = {a[7:1], 1'b1};
      if (p <= 3'd1) return (i == 0) ? a : c;
      case (i)
         0: return aw;
         1: return c;
         2: return a[0] ? ar : d0;
         default: return d1;
      endcase
   endfunction

   // returns number of negedges with busy observed high, starting the cycle after start
   task automatic wait_idle(output int cyc);
      reg_addr = 4'd0;
      #1;
      chk("R3", "busy after start", 16'(reg_rdata[0]), 16'd1);
      cyc = 1;
      for (int k = 0; k < 4000; k++) begin
         @(negedge clk);
         #1;
         if (!reg_rdata[0]) break;
         cyc++;
      end
   endtask

   task automatic run_xact(input logic [2:0] p, input logic [7:0] a, c, d0, d1,
                           input logic [15:0] dw, input logic nk, input logic ab);
      int cyc, n_exp, t_exp;
      logic [7:0] v, e_st, e_d0, e_d1;
      logic good, legal;
      wr(4'd4, a); wr(4'd3, c); wr(4'd5, d0); wr(4'd6, d1);
      dev_word = dw; nack_inj = nk; arb_inj = ab;
      wr(4'd0, 8'hFF);
      txq.delete();
      wr(4'd2, {3'b010, p, 2'b00});
      wait_idle(cyc);
      legal = (p <= 3'd3);
      good = legal && !nk && !ab;
      n_exp = !legal ? 0 : (good ? ntx(p, a[0]) : 1);
      t_exp = !legal ? 1 : (good ? nslots(p, a[0]) * SLOT : SLOT);
      e_st = !legal ? 8'h10 : ab ? 8'h08 : nk ? 8'h04 : 8'h02;
      chk(legal ? "R4" : "R9", "busy cycles", 16'(cyc), 16'(t_exp));
      chk("R7", "status at end", 16'(reg_rdata), 16'(e_st));
      chk(good ? "R4" : "R8", "tx count", 16'(txq.size()), 16'(n_exp));
      for (int i = 0; i < n_exp && i < txq.size(); i++)
         chk(p == 3'd1 ? "R5" : "R4", "tx byte", 16'(txq[i]), 16'(expb(p, a, c, d0, d1, i)));
      e_d0 = (good && a[0] && p != 3'd0) ? dw[7:0] : d0;
      e_d1 = (good && a[0] && p == 3'd3) ? dw[15:8] : d1;
      rd(4'd5, v); chk("R6", "data-low", 16'(v), 16'(e_d0));
      rd(4'd6, v); chk("R6", "data-high", 16'(v), 16'(e_d1));
      nack_inj = 1'b0; arb_inj = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] v;
      int cyc;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R2 reset state and map
      for (int o = 0; o < 8; o++) begin
         rd(4'(o), v); chk("R1", "reset value", 16'(v), 16'd0);
      end
      rd(4'd7, v); chk("R2", "unmapped offset", 16'(v), 16'd0);
      chk("R1", "tx after reset", 16'(txq.size()), 16'd0);

      // R2 control readback; R10 kill while idle
      wr(4'd2, 8'h8E);
      rd(4'd2, v); chk("R2", "control readback", 16'(v), 16'h008C);
      rd(4'd0, v); chk("R10", "idle kill status", 16'(v), 16'd0);
      wr(4'd2, 8'h42);
      rd(4'd0, v); chk("R10", "start with kill idle", 16'(v), 16'd0);

      // directed protocol cases
      run_xact(3'd1, 8'hA4, 8'h5B, 8'h00, 8'h00, 16'h0000, 0, 0); // R5 byte write
      run_xact(3'd3, 8'h51, 8'h07, 8'h11, 8'h22, 16'hBEEF, 0, 0); // R6 word read
      run_xact(3'd2, 8'h35, 8'h09, 8'h44, 8'h55, 16'h1234, 0, 0); // R6 byte-data read
      run_xact(3'd0, 8'h61, 8'h00, 8'h00, 8'h00, 16'h0000, 0, 0); // quick
      run_xact(3'd3, 8'h40, 8'h01, 8'h02, 8'h03, 16'h0000, 1, 0); // R8 nack
      run_xact(3'd2, 8'h41, 8'h01, 8'h02, 8'h03, 16'hFFFF, 1, 1); // R8 arb wins
      run_xact(3'd5, 8'h40, 8'h01, 8'h02, 8'h03, 16'h0000, 0, 0); // R9 unsupported

      // R10 kill during a running transaction
      wr(4'd0, 8'hFF); txq.delete();
      wr(4'd4, 8'h20); wr(4'd2, 8'h4C);
      repeat (4) @(negedge clk);
      wr(4'd2, 8'h02);
      reg_addr = 4'd0; #1;
      chk("R10", "status after kill", 16'(reg_rdata), 16'h0010);
      repeat (60) @(negedge clk);
      chk("R10", "tx after kill", 16'(txq.size()), 16'd0);

      // R12 writes while busy are ignored
      wr(4'd0, 8'hFF); txq.delete();
      wr(4'd4, 8'h30); wr(4'd3, 8'h11); wr(4'd5, 8'h22); wr(4'd6, 8'h33);
      wr(4'd2, 8'h4C);
      wr(4'd2, 8'h40); wr(4'd5, 8'h99); wr(4'd4, 8'h77); wr(4'd3, 8'h66);
      reg_addr = 4'd0;
      for (int k = 0; k < 4000; k++) begin
         @(negedge clk); #1;
         if (!reg_rdata[0]) break;
      end
      chk("R12", "status", 16'(reg_rdata), 16'h0002);
      chk("R12", "tx count", 16'(txq.size()), 16'd4);
      if (txq.size() == 4) begin
         chk("R12", "tx0", 16'(txq[0]), 16'h0030);
         chk("R12", "tx2", 16'(txq[2]), 16'h0022);
         chk("R12", "tx3", 16'(txq[3]), 16'h0033);
      end
      rd(4'd5, v); chk("R12", "data-low kept", 16'(v), 16'h0022);
      rd(4'd4, v); chk("R12", "address kept", 16'(v), 16'h0030);
      rd(4'd2, v); chk("R12", "control kept", 16'(v), 16'h000C);

      // R11 / R13 status write-one-to-clear and alert edge
      @(negedge clk); alert_in = 1'b1;
      rd(4'd0, v); rd(4'd0, v); chk("R13", "alert set", 16'(v), 16'h0022);
      wr(4'd0, 8'h00); rd(4'd0, v); chk("R11", "write zero", 16'(v), 16'h0022);
      wr(4'd0, 8'h02); rd(4'd0, v); chk("R11", "clear complete", 16'(v), 16'h0020);
      wr(4'd0, 8'h01); rd(4'd0, v); chk("R11", "busy bit write", 16'(v), 16'h0020);
      wr(4'd0, 8'h20); rd(4'd0, v); chk("R13", "held level no reset", 16'(v), 16'h0000);
      alert_in = 1'b0;

      // constrained random transactions
      for (int n = 0; n < 60; n++) begin
         logic [2:0] p;
         p = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(4, 7)) : 3'($urandom_range(0, 3));
         run_xact(p, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 16'($urandom),
                  $urandom_range(0, 7) == 0, $urandom_range(0, 9) == 0);
      end

      summary();
      $finish;
   end
endmodule